// File: doc/BRIEF.md
# In-System Programming Host Sequencer

This block is the host end of a four-wire serial programming link. From reset it holds the target's active-low reset line and the serial clock low. It then gives the reset line one positive pulse and waits a long, parameterised settling interval. After that it clocks out the four-byte "enter programming" instruction, `0xAC 0x53 0x00 0x00`. A target that is in step echoes the second byte back while the host sends the third byte. The sequencer compares that echo with `0x53` before it declares the link usable.

When the echo is wrong, the sequencer pulses the reset line again, waits out the settling interval and repeats the instruction. It makes a bounded number of extra attempts and then stops in a sticky error state. Once the link is in step, the sequencer accepts user instructions one at a time. Each is a 32-bit word given through a valid/ready handshake. The sequencer clocks it out MSB first and returns the byte received during the fourth byte, together with a one-cycle completion strobe.

The state machine has these states:

- `ST_HOLD`: lines held low after reset.
- `ST_PULSE`: reset line high.
- `ST_SETTLE`: wait after the pulse.
- `ST_ENTER`: launch the enable instruction.
- `ST_ECHO`: await the enable instruction and judge the echo.
- `ST_READY`: idle and synchronised.
- `ST_CMD`: user instruction in flight.
- `ST_ERROR`: retries exhausted.

The transitions are:

- HOLD→PULSE after `HOLD_CYC` cycles.
- PULSE→SETTLE after `PULSE_CYC` cycles.
- SETTLE→ENTER after `SETTLE_CYC` cycles.
- ENTER→ECHO unconditionally.
- ECHO→READY on a good echo.
- ECHO→PULSE on a bad echo with retries left.
- ECHO→ERROR on a bad echo with none left.
- READY→CMD on a handshake.
- CMD→READY when the last bit is done.

Top module: `isp_host_seq`

## Requirements
- R1: After reset release, the reset line, `sck_o`, `mosi_o`, `cmd_ready_o`, `sync_ok_o`, `sync_fail_o` and `rsp_done_o` are all 0. The reset line first rises on the `HOLD_CYC`-th clock edge after release.
- R2: Each reset pulse is high for exactly `PULSE_CYC` clock cycles, and `sck_o` stays low throughout it.
- R3: After each falling edge of the reset line, no rising edge of `sck_o` occurs for at least `SETTLE_CYC` cycles.
- R4: During a transfer, every high phase and every low phase of `sck_o` lasts exactly `HALF_CYC` clock cycles. `mosi_o` carries the word MSB first and does not change while `sck_o` is high.
- R5: `miso_i` is sampled in the last cycle of each `sck_o` high phase, so the first bit received in each byte becomes its MSB.
- R6: The enable instruction is the byte sequence `0xAC`, `0x53`, `0x00`, `0x00`, in that order.
- R7: The link is declared in step (`sync_ok_o`=1, `cmd_ready_o`=1) only when bits 15..8 of the word received during the enable instruction, which is the byte received while sending the third byte, equal `0x53`.
- R8: On a wrong echo the reset line is pulsed again and the enable instruction repeated, up to `MAX_RETRY` extra attempts. After `1+MAX_RETRY` failed attempts, `sync_fail_o` rises and stays high until reset, with no further `sck_o` activity. `sync_ok_o` and `sync_fail_o` are never high together.
- R9: A user word is accepted on a cycle with `cmd_valid_i` and `cmd_ready_o` both high. `cmd_ready_o` stays low until that instruction completes, and the four bytes of the word go out MSB byte first.
- R10: On completion, `rsp_done_o` is high for exactly one cycle, and `rsp_byte_o` carries the byte received during the fourth byte. `rsp_byte_o` does not change on any other cycle.
- R11: Between instructions, and in the ready state, `sck_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the sequencer |
| tgt_reset_o | output | 1 | Level driven onto the target's active-low reset pin (1 = pulse) |
| sck_o | output | 1 | Serial clock to the target |
| mosi_o | output | 1 | Serial data to the target |
| miso_i | input | 1 | Serial data from the target |
| cmd_valid_i | input | 1 | User instruction valid |
| cmd_ready_o | output | 1 | Sequencer can accept an instruction |
| cmd_word_i | input | 32 | User instruction, first byte in bits 31..24 |
| rsp_done_o | output | 1 | One-cycle strobe at instruction completion |
| rsp_byte_o | output | 8 | Byte received during the fourth byte |
| sync_ok_o | output | 1 | Link is in step |
| sync_fail_o | output | 1 | Retries exhausted (sticky) |

## Verification
The bench uses a target model that gives back each received byte one byte later. It can also be told to answer all ones for a chosen number of reset pulses. With that, the bench covers a clean entry, entry after exactly the last allowed retry, and one failure past the limit. An off-by-one retry counter either gives up one attempt early or never raises the error flag. Pulse widths, the settle gap and both clock phases are measured at the pins. A wrong terminal count in any timer shows up as a phase or pulse length that is off by a cycle. A sampling point one phase late shifts every returned byte by one bit, which the fourth-byte check on two different user words exposes.

// File: rtl/isp_host_pkg.sv
package isp_host_pkg;

    typedef enum logic [3:0] {
        ST_HOLD,
        ST_PULSE,
        ST_SETTLE,
        ST_ENTER,
        ST_ECHO,
        ST_READY,
        ST_CMD,
        ST_ERROR
    } seq_state_t;

    localparam int          WORD_BITS  = 32;
    localparam logic [31:0] ENTER_WORD = 32'hAC53_0000;
    localparam logic [7:0]  ECHO_BYTE  = 8'h53;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/isp_timer.sv
module isp_timer #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= RST_VAL;
        else if (load_i)
            cnt_q <= val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/isp_shift.sv
module isp_shift #(
    parameter int NBITS    = 32,
    parameter int HALF_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NBITS-1:0] word_i,
    input  logic             miso_i,
    output logic             sck_o,
    output logic             mosi_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [NBITS-1:0] rx_o
);
    localparam int PW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int BW = (NBITS > 1) ? $clog2(NBITS) : 1;
    localparam logic [PW-1:0] PH_LAST  = PW'(HALF_CYC - 1);
    localparam logic [BW-1:0] BIT_LAST = BW'(NBITS - 1);

    logic [NBITS-1:0] tx_q, rx_q;
    logic [PW-1:0]    ph_q;
    logic [BW-1:0]    bit_q;
    logic             busy_q, sck_q, done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q   <= '0;
            rx_q   <= '0;
            ph_q   <= '0;
            bit_q  <= '0;
            busy_q <= 1'b0;
            sck_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q <= 1'b1;
                    tx_q   <= word_i;
                    ph_q   <= '0;
                    bit_q  <= '0;
                    sck_q  <= 1'b0;
                end
            end else if (ph_q != PH_LAST) begin
                ph_q <= ph_q + 1'b1;
            end else begin
                ph_q <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                end else begin
                    sck_q <= 1'b0;
                    rx_q  <= {rx_q[NBITS-2:0], miso_i};
                    tx_q  <= {tx_q[NBITS-2:0], 1'b0};
                    bit_q <= bit_q + 1'b1;
                    if (bit_q == BIT_LAST) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign sck_o  = sck_q;
    assign mosi_o = tx_q[NBITS-1];
    assign busy_o = busy_q;
    assign done_o = done_q;
    assign rx_o   = rx_q;
endmodule

// File: rtl/isp_host_seq.sv
module isp_host_seq
    import isp_host_pkg::*;
#(
    parameter int HOLD_CYC   = 16,
    parameter int PULSE_CYC  = 8,
    parameter int SETTLE_CYC = 4_000_000,
    parameter int HALF_CYC   = 4,
    parameter int MAX_RETRY  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        tgt_reset_o,
    output logic        sck_o,
    output logic        mosi_o,
    input  logic        miso_i,
    input  logic        cmd_valid_i,
    output logic        cmd_ready_o,
    input  logic [31:0] cmd_word_i,
    output logic        rsp_done_o,
    output logic [7:0]  rsp_byte_o,
    output logic        sync_ok_o,
    output logic        sync_fail_o
);
    localparam int MAXC = max3(HOLD_CYC, PULSE_CYC, SETTLE_CYC);
    localparam int TW   = $clog2(MAXC + 1);
    localparam int RW   = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;
    localparam logic [TW-1:0] HOLD_LD   = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] PULSE_LD  = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);
    localparam logic [RW-1:0] TRY_LAST  = RW'(MAX_RETRY);

    seq_state_t state_q, state_d;
    logic [RW-1:0]        tries_q;
    logic                 tmr_zero, tmr_load;
    logic [TW-1:0]        tmr_val;
    logic                 sh_start, sh_busy, sh_done;
    logic [WORD_BITS-1:0] sh_word, sh_rx;
    logic                 echo_good;
    logic                 done_q;
    logic [7:0]           byte_q;

    isp_timer #(.W(TW), .RST_VAL(HOLD_LD)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    isp_shift #(.NBITS(WORD_BITS), .HALF_CYC(HALF_CYC)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sh_start),
        .word_i  (sh_word),
        .miso_i  (miso_i),
        .sck_o   (sck_o),
        .mosi_o  (mosi_o),
        .busy_o  (sh_busy),
        .done_o  (sh_done),
        .rx_o    (sh_rx)
    );

    assign echo_good = (sh_rx[15:8] == ECHO_BYTE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_HOLD;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:   if (tmr_zero) state_d = ST_PULSE;
            ST_PULSE:  if (tmr_zero) state_d = ST_SETTLE;
            ST_SETTLE: if (tmr_zero) state_d = ST_ENTER;
            ST_ENTER:  state_d = ST_ECHO;
            ST_ECHO: begin
                if (sh_done) begin
                    if (echo_good)
                        state_d = ST_READY;
                    else if (tries_q == TRY_LAST)
                        state_d = ST_ERROR;
                    else
                        state_d = ST_PULSE;
                end
            end
            ST_READY:  if (cmd_valid_i) state_d = ST_CMD;
            ST_CMD:    if (sh_done) state_d = ST_READY;
            ST_ERROR:  state_d = ST_ERROR;
            default:   state_d = ST_ERROR;
        endcase
    end

    // retry count and response capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tries_q <= '0;
            done_q  <= 1'b0;
            byte_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_ECHO && sh_done && !echo_good && tries_q != TRY_LAST)
                tries_q <= tries_q + 1'b1;
            if (state_q == ST_CMD && sh_done) begin
                done_q <= 1'b1;
                byte_q <= sh_rx[7:0];
            end
        end
    end

    // outputs
    always_comb begin
        tgt_reset_o = 1'b0;
        cmd_ready_o = 1'b0;
        sync_ok_o   = 1'b0;
        sync_fail_o = 1'b0;
        sh_start    = 1'b0;
        sh_word     = ENTER_WORD;
        tmr_load    = (state_d != state_q);
        tmr_val     = '0;
        unique case (state_d)
            ST_PULSE:  tmr_val = PULSE_LD;
            ST_SETTLE: tmr_val = SETTLE_LD;
            default:   tmr_val = '0;
        endcase
        unique case (state_q)
            ST_PULSE:  tgt_reset_o = 1'b1;
            ST_ENTER:  sh_start = !sh_busy;
            ST_READY: begin
                cmd_ready_o = 1'b1;
                sync_ok_o   = 1'b1;
                sh_start    = cmd_valid_i;
                sh_word     = cmd_word_i;
            end
            ST_CMD:    sync_ok_o = 1'b1;
            ST_ERROR:  sync_fail_o = 1'b1;
            default:   ;
        endcase
    end

    assign rsp_done_o = done_q;
    assign rsp_byte_o = byte_q;
endmodule

// File: rtl/isp_host_chk.sv
module isp_host_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tgt_reset_o,
    input logic       sck_o,
    input logic       mosi_o,
    input logic       cmd_ready_o,
    input logic       rsp_done_o,
    input logic [7:0] rsp_byte_o,
    input logic       sync_ok_o,
    input logic       sync_fail_o
);
    AST_SCK_QUIET_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_reset_o |-> !sck_o); // R2

    AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o)); // R4

    AST_READY_MEANS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready_o |-> sync_ok_o); // R7

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sync_fail_o |=> (sync_fail_o && !sck_o)); // R8

    AST_OK_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_ok_o && sync_fail_o)); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done_o |=> !rsp_done_o); // R10

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done_o |-> $stable(rsp_byte_o)); // R10

    AST_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready_o |-> !sck_o); // R11
endmodule

bind isp_host_seq isp_host_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tgt_reset_o (tgt_reset_o),
    .sck_o       (sck_o),
    .mosi_o      (mosi_o),
    .cmd_ready_o (cmd_ready_o),
    .rsp_done_o  (rsp_done_o),
    .rsp_byte_o  (rsp_byte_o),
    .sync_ok_o   (sync_ok_o),
    .sync_fail_o (sync_fail_o)
);

// File: tb/isp_host_seq_test.sv
`timescale 1ns/1ps
module isp_host_seq_test;
    localparam int HOLD   = 10;
    localparam int PULSE  = 4;
    localparam int SETTLE = 50;
    localparam int HALF   = 3;
    localparam int RETRY  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tgt_reset_o, sck_o, mosi_o, miso_i;
    logic        cmd_valid_i = 1'b0;
    logic [31:0] cmd_word_i = '0;
    logic        cmd_ready_o, rsp_done_o, sync_ok_o, sync_fail_o;
    logic [7:0]  rsp_byte_o;

    always #2.5 clk = ~clk;

    isp_host_seq #(.HOLD_CYC(HOLD), .PULSE_CYC(PULSE), .SETTLE_CYC(SETTLE),
                   .HALF_CYC(HALF), .MAX_RETRY(RETRY)) uut (
        .clk(clk), .rst_n(rst_n), .tgt_reset_o(tgt_reset_o), .sck_o(sck_o),
        .mosi_o(mosi_o), .miso_i(miso_i), .cmd_valid_i(cmd_valid_i),
        .cmd_ready_o(cmd_ready_o), .cmd_word_i(cmd_word_i),
        .rsp_done_o(rsp_done_o), .rsp_byte_o(rsp_byte_o),
        .sync_ok_o(sync_ok_o), .sync_fail_o(sync_fail_o));

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // target model: echoes each received byte during the next byte
    logic [7:0] t_in = '0, t_out = '0;
    int  t_cnt = 0;
    bit  t_bad = 0;
    int  fails_left = 0;
    logic [7:0] rx_log [0:15];
    int  nlog = 0;

    always @(posedge tgt_reset_o) begin
        t_cnt = 0; t_in = '0; t_out = '0;
        t_bad = (fails_left > 0);
        if (fails_left > 0) fails_left--;
    end
    always @(posedge sck_o) begin
        t_in = {t_in[6:0], mosi_o};
        t_cnt++;
        if (t_cnt == 8) begin
            if (nlog < 16) rx_log[nlog] = t_in;
            nlog++;
        end
    end
    always @(negedge sck_o) begin
        if (t_cnt == 8) begin t_out = t_in; t_cnt = 0; end
        else t_out = {t_out[6:0], 1'b0};
    end
    assign miso_i = t_bad ? 1'b1 : t_out[7];

    // pin monitor
    bit prev_sck = 0, prev_line = 0, await_rise = 0;
    int hi_run = 0, lo_run = 0, min_lo = 1000, bad_hi = 0;
    int line_run = 0, bad_pulse = 0, npulse = 0, gap = 0, min_gap = 1000;
    int sck_rises = 0;

    task automatic clear_mon();
        hi_run = 0; lo_run = 0; min_lo = 1000; bad_hi = 0;
        line_run = 0; bad_pulse = 0; npulse = 0; gap = 0; min_gap = 1000;
        await_rise = 0; sck_rises = 0; nlog = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (sck_o) begin
                if (!prev_sck) begin
                    sck_rises++;
                    if (lo_run < min_lo) min_lo = lo_run;
                    if (await_rise) begin
                        if (gap < min_gap) min_gap = gap;
                        await_rise = 0;
                    end
                    hi_run = 1;
                end else hi_run++;
                lo_run = 0;
            end else begin
                if (prev_sck) begin
                    if (hi_run != HALF) bad_hi++;
                    lo_run = 1;
                end else lo_run++;
            end
            if (tgt_reset_o) line_run++;
            else if (prev_line) begin
                if (line_run != PULSE) bad_pulse++;
                npulse++;
                line_run = 0;
                await_rise = 1;
                gap = 0;
            end
            if (await_rise && !tgt_reset_o) gap++;
        end
        prev_sck = sck_o;
        prev_line = tgt_reset_o;
    end

    task automatic do_reset(input int fails);
        rst_n = 1'b0;
        cmd_valid_i = 1'b0;
        fails_left = fails;
        repeat (3) @(negedge clk);
        clear_mon();
        rst_n = 1'b1;
    endtask

    task automatic wait_settled();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (sync_ok_o || sync_fail_o) break;
        end
    endtask

    task automatic t_reset_state();
        int k;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(tgt_reset_o == 0 && sck_o == 0 && mosi_o == 0, "R1", "lines in reset", {tgt_reset_o, sck_o, mosi_o}, 0);
        chk(cmd_ready_o == 0 && sync_ok_o == 0 && sync_fail_o == 0 && rsp_done_o == 0, "R1", "flags in reset",
            {cmd_ready_o, sync_ok_o, sync_fail_o, rsp_done_o}, 0);
        do_reset(0);
        k = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            k++;
            if (tgt_reset_o) break;
            if (sck_o) break;
        end
        chk(k == HOLD && tgt_reset_o == 1 && sck_o == 0, "R1", "hold length before pulse", k, HOLD);
    endtask

    task automatic t_sync_good();
        do_reset(0);
        wait_settled();
        chk(sync_ok_o == 1 && cmd_ready_o == 1, "R7", "in step with good echo", {sync_ok_o, cmd_ready_o}, 3);
        chk(npulse == 1 && bad_pulse == 0, "R2", "single pulse of right width", {npulse, bad_pulse}, 64'h1_0000_0000);
        chk(min_gap >= SETTLE, "R3", "settle gap", min_gap, SETTLE);
        chk(bad_hi == 0 && min_lo == HALF, "R4", "sck phase widths", {bad_hi, min_lo}, HALF);
        chk(nlog == 4 && rx_log[0] == 8'hAC && rx_log[1] == 8'h53 && rx_log[2] == 8'h00 && rx_log[3] == 8'h00,
            "R6", "enable bytes", {rx_log[0], rx_log[1], rx_log[2], rx_log[3]}, 32'hAC53_0000);
    endtask

    task automatic t_command(input logic [31:0] w, input logic [7:0] exp_b);
        int done_cnt;
        int base;
        base = nlog;
        while (!cmd_ready_o) @(negedge clk);
        cmd_word_i = w;
        cmd_valid_i = 1'b1;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        cmd_word_i = '0;
        chk(cmd_ready_o == 0, "R9", "ready drops after accept", cmd_ready_o, 0);
        done_cnt = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (rsp_done_o) begin
                done_cnt++;
                @(negedge clk);
                if (rsp_done_o) done_cnt++;
                break;
            end
            if (cmd_ready_o) break;
        end
        chk(done_cnt == 1, "R10", "done strobe width", done_cnt, 1);
        chk(rsp_byte_o == exp_b, "R5", "fourth byte sampled", rsp_byte_o, exp_b);
        chk(nlog - base == 4 && rx_log[base] == w[31:24] && rx_log[base+1] == w[23:16]
            && rx_log[base+2] == w[15:8] && rx_log[base+3] == w[7:0], "R9", "word order on wire",
            {rx_log[base], rx_log[base+1], rx_log[base+2], rx_log[base+3]}, w);
        begin
            int hi = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (sck_o) hi++;
            end
            chk(hi == 0 && cmd_ready_o == 1, "R11", "sck idle low after instruction", hi, 0);
            chk(rsp_byte_o == exp_b, "R10", "result held", rsp_byte_o, exp_b);
        end
        chk(bad_hi == 0 && min_lo == HALF, "R4", "phase widths in instruction", {bad_hi, min_lo}, HALF);
    endtask

    task automatic t_retry_last();
        do_reset(RETRY);
        wait_settled();
        chk(sync_ok_o == 1 && sync_fail_o == 0, "R8", "in step on final retry", {sync_ok_o, sync_fail_o}, 2);
        chk(npulse == RETRY + 1 && bad_pulse == 0, "R8", "pulses for retries", npulse, RETRY + 1);
        chk(min_gap >= SETTLE, "R3", "settle gap on retries", min_gap, SETTLE);
    endtask

    task automatic t_give_up();
        int rises;
        do_reset(RETRY + 1);
        wait_settled();
        chk(sync_fail_o == 1 && sync_ok_o == 0 && cmd_ready_o == 0, "R8", "error after limit",
            {sync_fail_o, sync_ok_o, cmd_ready_o}, 4);
        chk(npulse == RETRY + 1, "R8", "attempt count", npulse, RETRY + 1);
        rises = sck_rises;
        cmd_word_i = 32'h1111_2222;
        cmd_valid_i = 1'b1;
        repeat (300) @(negedge clk);
        cmd_valid_i = 1'b0;
        chk(sck_rises == rises && sync_fail_o == 1 && npulse == RETRY + 1, "R8", "quiet and sticky",
            sck_rises - rises, 0);
        chk(rsp_done_o == 0 && cmd_ready_o == 0, "R7", "no accept when not in step", {rsp_done_o, cmd_ready_o}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: run did not complete, actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_sync_good();
        t_command(32'h1234_5678, 8'h56);
        t_command(32'hA5C3_F00F, 8'hF0);
        t_retry_last();
        t_command(32'h0F0E_8001, 8'h80);
        t_give_up();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule